// File: doc/BRIEF.md
# Front-End Serial Configuration Loader

This block is a write-only serial master. It loads 24-bit configuration words into two external front-end parts: a frequency synthesizer and an IF device. The local controller places a word on `word_i`, picks the destination with `target_i` and pulses `start_i` for one cycle. The block then drives the word out serially, one bit per serial clock, starting with the most significant bit. While the word is on the wire, it holds a load-enable line high for the chosen part only.

The serial clock is made from the system clock by a parameterised divider, and it idles low. The data line changes only while the serial clock is low, so the receiving part can latch each bit on the rising edge. The serial lines belong to this block alone, so no other traffic can toggle them. A one-cycle `done_o` pulse marks the end of each transfer. It comes after the load enable has dropped. While `busy_o` is high, further start requests are dropped.

Top module: `synth_prog_port`

## Requirements
- R1: The bits sampled on the serial data line at each rising serial-clock edge of a transfer are the latched word from bit DATA_W-1 down to bit 0, most significant first.
- R2: Each transfer produces exactly DATA_W rising serial-clock edges (24 by default).
- R3: The serial data line never changes while the serial clock is high, nor in the cycle the serial clock rises.
- R4: With `target_i` = 0 only `le_rf_o` is raised, and with `target_i` = 1 only `le_if_o` is raised. The two enables are never high together.
- R5: The selected enable rises in the first cycle after the accepted start, HALF_DIV cycles before the first rising serial-clock edge. It falls together with the last falling serial-clock edge, HALF_DIV cycles after the last rising edge. The serial clock is high only while an enable is high.
- R6: After reset, and whenever idle, the serial clock and both enables are low. After a transfer the data line keeps the last bit sent (bit 0). Reset clears the data line, `busy_o` and `done_o`.
- R7: `busy_o` is high from the first cycle after an accepted start until the cycle `done_o` pulses. `done_o` is high for one cycle, exactly one cycle after the enable falls.
- R8: A `start_i` pulse that arrives while `busy_o` is high is ignored: the current word and target are sent unchanged, and no second transfer follows.
- R9: Consecutive rising serial-clock edges are 2*HALF_DIV system cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to send `word_i` |
| word_i | input | DATA_W | Configuration word to send |
| target_i | input | 1 | Destination: 0 = synthesizer, 1 = IF device |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse at the end of a transfer |
| sclk_o | output | 1 | Serial clock, idles low |
| sdata_o | output | 1 | Serial data, MSB first |
| le_rf_o | output | 1 | Active-high load enable for the synthesizer |
| le_if_o | output | 1 | Active-high load enable for the IF device |

## Verification
The bound checker checks, on every cycle, the rules that hold at each moment of a frame:
- the data line is quiet while the clock is high;
- the two enables exclude each other;
- the clock stays inside the frame;
- quiet idle outputs;
- the done pulse is one cycle wide and busy falls only with it;
- a count of rising edges equal to DATA_W at the moment the enable falls.

Three things need the bench's scenarios: that the captured bits reproduce the requested word in MSB-first order, the exact cycle offsets of the enable edges relative to the clock edges, and that a start request during a transfer leaves the word and target untouched.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_FIN   = 2'd2
  } seq_state_t;

  typedef enum logic {
    DEST_SYNTH = 1'b0,
    DEST_IF    = 1'b1
  } dest_t;

endpackage

// File: rtl/spp_half_tick.sv
module spp_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  generate
    if (HALF_DIV <= 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam int CNT_W = $clog2(HALF_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || !run) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = run && (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/spp_shifter.sv
module spp_shifter #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] word,
  input  logic              shift,
  output logic              sdata
);

  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      sdata <= 1'b0;
    end else if (load) begin
      sr_q  <= word;
      sdata <= word[DATA_W-1];
    end else if (shift) begin
      sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
      sdata <= sr_q[DATA_W-2];
    end
  end

endmodule

// File: rtl/spp_seq.sv
module spp_seq
  import synth_prog_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic target,
  input  logic tick,
  output logic run,
  output logic load,
  output logic shift,
  output logic sclk,
  output logic le_rf,
  output logic le_if,
  output logic busy,
  output logic done
);

  localparam int NPH  = 2 * DATA_W;
  localparam int PH_W = $clog2(NPH);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(NPH - 1);

  seq_state_t      st_q;
  logic [PH_W-1:0] ph_q;
  dest_t           dest_q;
  logic            last_ph;

  assign run     = (st_q == SEQ_SHIFT);
  assign load    = (st_q == SEQ_IDLE) && start;
  assign last_ph = (ph_q == PH_LAST);
  assign shift   = run && tick && sclk && !last_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_IDLE;
      ph_q   <= '0;
      dest_q <= DEST_SYNTH;
      sclk   <= 1'b0;
      le_rf  <= 1'b0;
      le_if  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        SEQ_IDLE: begin
          if (start) begin
            st_q   <= SEQ_SHIFT;
            ph_q   <= '0;
            dest_q <= dest_t'(target);
            busy   <= 1'b1;
            le_rf  <= (dest_t'(target) == DEST_SYNTH);
            le_if  <= (dest_t'(target) == DEST_IF);
          end
        end
        SEQ_SHIFT: begin
          if (tick) begin
            if (last_ph) begin
              sclk  <= 1'b0;
              le_rf <= 1'b0;
              le_if <= 1'b0;
              st_q  <= SEQ_FIN;
            end else begin
              sclk <= ~sclk;
              ph_q <= ph_q + 1'b1;
            end
          end
        end
        SEQ_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          st_q <= SEQ_IDLE;
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port #(
  parameter int DATA_W   = 24,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              target_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              le_rf_o,
  output logic              le_if_o
);

  logic run, tick, load, shift;

  spp_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  spp_seq #(.DATA_W(DATA_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start_i),
    .target(target_i),
    .tick  (tick),
    .run   (run),
    .load  (load),
    .shift (shift),
    .sclk  (sclk_o),
    .le_rf (le_rf_o),
    .le_if (le_if_o),
    .busy  (busy_o),
    .done  (done_o)
  );

  spp_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .word (word_i),
    .shift(shift),
    .sdata(sdata_o)
  );

endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk #(
  parameter int DATA_W = 24
) (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic sdata_o,
  input logic le_rf_o,
  input logic le_if_o
);

  localparam int CW = $clog2(DATA_W + 1) + 1;
  logic          sclk_d;
  logic [CW-1:0] rise_cnt;
  logic          en_any;

  assign en_any = le_rf_o || le_if_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (!busy_o) begin
        rise_cnt <= '0;
      end else if (sclk_o && !sclk_d) begin
        rise_cnt <= rise_cnt + 1'b1;
      end
    end
  end

  AST_DATA_QUIET_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sdata_o != $past(sdata_o)) |-> !sclk_o); // R3

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !(le_rf_o && le_if_o)); // R4

  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> en_any); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!sclk_o && !en_any)); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!en_any && $past(busy_o))); // R7

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o); // R7

  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (rst)
    $fell(en_any) |-> (rise_cnt == CW'(DATA_W))); // R2

endmodule

bind synth_prog_port synth_prog_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy_o (busy_o),
  .done_o (done_o),
  .sclk_o (sclk_o),
  .sdata_o(sdata_o),
  .le_rf_o(le_rf_o),
  .le_if_o(le_if_o)
);

// File: tb/synth_prog_port_tb.sv
module synth_prog_port_tb;

  localparam int W = 24;
  localparam int H = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         target_i = 1'b0;
  logic         busy_o, done_o, sclk_o, sdata_o, le_rf_o, le_if_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  synth_prog_port #(.DATA_W(W), .HALF_DIV(H)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
    .target_i(target_i), .busy_o(busy_o), .done_o(done_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .le_rf_o(le_rf_o), .le_if_o(le_if_o)
  );

  function automatic int first_rise_t(); return H; endfunction
  function automatic int en_fall_t();    return 2 * W * H; endfunction
  function automatic int done_t_exp();   return 2 * W * H + 1; endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [W-1:0] word, input logic tgt, input bit inject);
    logic [W-1:0] rx = '0;
    int rises = 0, t = 0, first_r = -1, prev_r = -1, bad_gap = 0;
    int fall_t = -1, dn_t = -1, dn_cnt = 0, hi_change = 0, other_hi = 0;
    int sel_low_early = 0, busy_bad = 0;
    logic p_sclk, p_sdata, p_sel, sel_now;
    @(negedge clk);
    word_i = word; target_i = tgt; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    p_sclk = 1'b0; p_sdata = sdata_o; p_sel = 1'b1;
    chk((tgt ? le_if_o : le_rf_o) == 1'b1, "R5 enable at t0", 0, 1);
    while (t < 4 * W * H + 20) begin
      if (inject && t == 5) begin word_i = ~word; target_i = ~tgt; start_i = 1'b1; end
      if (inject && t == 6) start_i = 1'b0;
      sel_now = tgt ? le_if_o : le_rf_o;
      if ((tgt ? le_rf_o : le_if_o)) other_hi++;
      if (sdata_o != p_sdata && sclk_o) hi_change++;
      if (sclk_o && !p_sclk) begin
        if (p_sdata != sdata_o) hi_change++;
        rx = {rx[W-2:0], sdata_o};
        if (first_r < 0) first_r = t;
        if (prev_r >= 0 && (t - prev_r) != 2 * H) bad_gap++;
        prev_r = t;
        rises++;
      end
      if (!sel_now && p_sel && fall_t < 0) fall_t = t;
      if (fall_t < 0 && !sel_now) sel_low_early++;
      if (done_o) begin dn_cnt++; if (dn_t < 0) dn_t = t; end
      if (dn_t < 0 && !busy_o) busy_bad++;
      if (dn_t >= 0 && t > dn_t + 3) break;
      p_sclk = sclk_o; p_sdata = sdata_o; p_sel = sel_now;
      @(negedge clk);
      t++;
    end
    chk(rx == word, "R1 word bits", rx, word);
    chk(rises == W, "R2 rising edges", rises, W);
    chk(hi_change == 0, "R3 data change while high", hi_change, 0);
    chk(other_hi == 0, "R4 other enable", other_hi, 0);
    chk(first_r == first_rise_t(), "R5 first rise", first_r, first_rise_t());
    chk(fall_t == en_fall_t(), "R5 enable fall", fall_t, en_fall_t());
    chk(bad_gap == 0, "R9 rise spacing", bad_gap, 0);
    chk(dn_t == done_t_exp(), "R7 done time", dn_t, done_t_exp());
    chk(dn_cnt == 1, "R7 done count", dn_cnt, 1);
    chk(busy_bad == 0, "R7 busy early drop", busy_bad, 0);
    chk(busy_o == 1'b0 && sclk_o == 1'b0 && !le_rf_o && !le_if_o, "R6 idle lines",
        {busy_o, sclk_o, le_rf_o, le_if_o}, 0);
    chk(sdata_o == word[0], "R6 data hold", sdata_o, word[0]);
    if (inject) chk(busy_o == 1'b0 && rx == word, "R8 busy start ignored", rx, word);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(!sclk_o && !sdata_o && !le_rf_o && !le_if_o && !busy_o && !done_o,
        "R6 reset state", {sclk_o, sdata_o, le_rf_o, le_if_o, busy_o, done_o}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!sclk_o && !busy_o, "R6 idle after reset", {sclk_o, busy_o}, 0);
    xfer(24'hFFFFFF, 1'b0, 1'b0);
    xfer(24'h000000, 1'b1, 1'b0);
    xfer(24'h800001, 1'b0, 1'b0);
    xfer(24'hA5A5A5, 1'b1, 1'b1);
    xfer(24'h5A5A5A, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) begin
      xfer(W'($urandom), 1'($urandom), ($urandom % 4) == 0);
      repeat ($urandom % 3) @(negedge clk);
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule